// File: doc/BRIEF.md
# Reservation Monitor for Atomic Read-Modify-Write

This block keeps one address reservation on behalf of a single processor, so that software can build atomic read-modify-write loops out of a reserving load and a conditional store. A reserving load records its byte address and arms the reservation. Writes by other agents that touch the same 32-byte region disarm it, and so do plain local stores to that region. When the processor later issues a conditional store, the block decides whether the store may reach memory. It raises a one-cycle memory write-enable when the store is allowed, and it reports the outcome in a 4-bit condition field.

The core side offers at most one of its three requests (reserving load, plain store, conditional store) per cycle. The snoop port, which reports writes from other agents, works independently of them. Interrupts and traps are signalled on their own input and leave the reservation untouched. Software that needs to drop a reservation, for example on a context switch, issues a conditional store to a harmless address.

The controller has two states. NO_RESV means no reservation is held. RESV_HELD means the reservation is armed. The transitions are:
- RESERVE (NO_RESV to RESV_HELD, on a reserving load)
- RELOAD (RESV_HELD to RESV_HELD with a new address, on a reserving load)
- CONSUME (RESV_HELD to NO_RESV, on any conditional store)
- KILL (RESV_HELD to NO_RESV, on a snoop or a local store that hits the granule)

Top module: `resv_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `resv_valid`, `mem_we` and `cr_vld` are 0 and `cr_fld` is 4'b0000. A reservation held before reset is gone afterwards.
- R2: A reserving load (`lr_req`) stores `lr_addr` and sets `resv_valid` one clock later. At most one of `lr_req`, `st_req`, `sc_req` is high in any cycle.
- R3: A snoop (`snp_req`) whose address matches the reserved address in bits [AW-1:5] clears `resv_valid` one clock later. A snoop to any other 32-byte granule has no effect.
- R4: A local plain store (`st_req`) to the reserved granule clears `resv_valid`. A store to any other granule leaves it set.
- R5: A conditional store (`sc_req`) succeeds only if a reservation is held and `sc_addr` equals the reserved address in bits [AW-1:2]. On success, `mem_we` is 1 in exactly the one cycle after the request, and the condition field has EQ (`cr_fld[1]`) set to 1.
- R6: Every conditional store writes `cr_fld` = {LT, GT, EQ, SO}, with LT (`cr_fld[3]`) = 0, GT (`cr_fld[2]`) = 0 and SO (`cr_fld[0]`) = `so_flag` sampled in the request cycle. On failure, EQ = 0 and `mem_we` stays 0.
- R7: After any conditional store, successful or not, `resv_valid` is 0.
- R8: A conditional store to a word other than the reserved one fails and drops the reservation, even inside the same granule.
- R9: If a snoop hits the reserved granule in the same cycle as a conditional store, the snoop wins and the store fails.
- R10: `trap_evt` has no effect on the reservation or on the store outcome.
- R11: A reservation that is never consumed stays valid indefinitely. A new reserving load replaces the reserved address, and later conditional stores are compared against the new address.
- R12: A reserving load and a snoop to its granule in the same cycle leave the new reservation valid.
- R13: `cr_vld` is 1 exactly in the cycle after each conditional store. `cr_fld` holds its value between conditional stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_req | input | 1 | Reserving load strobe |
| lr_addr | input | AW | Reserving load byte address |
| st_req | input | 1 | Local plain store strobe |
| st_addr | input | AW | Local plain store address |
| snp_req | input | 1 | Write by another agent observed |
| snp_addr | input | AW | Address of the observed write |
| sc_req | input | 1 | Conditional store strobe |
| sc_addr | input | AW | Conditional store address |
| so_flag | input | 1 | Current summary-overflow flag |
| trap_evt | input | 1 | Interrupt or trap taken (no effect on the reservation) |
| mem_we | output | 1 | Write-enable to memory for a successful conditional store |
| cr_vld | output | 1 | Condition field updated this cycle |
| cr_fld | output | 4 | Condition field {LT, GT, EQ, SO} |
| resv_valid | output | 1 | A reservation is held |

## Verification
The bench targets the places where a monitor tends to go wrong:
- A snoop that lands in the same cycle as a conditional store. A design that gives the store priority would write memory after another agent changed the data.
- A conditional store to a different word inside the reserved granule. A design that compares whole granules would report success.
- A failing conditional store. A design that frees the reservation only on success would let a later stray store succeed.
- Traps, long abandoned reservations, and a reload over a held reservation. Each of these catches designs that drop state too eagerly or compare against a stale address.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [0:0] {
        NO_RESV   = 1'b0,
        RESV_HELD = 1'b1
    } resv_state_e;

    // bit positions inside the condition field
    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;
    localparam int CR_W  = 4;

    // number of granule watchers (remote snoop, local store)
    localparam int N_WATCH = 2;

endpackage

// File: rtl/resv_granule_cmp.sv
module resv_granule_cmp #(
    parameter int AW   = 32,
    parameter int GLSB = 5
) (
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_addr,
    input  logic          held,
    output logic          hit
);
    localparam logic [AW-1:0] GMASK = {{(AW-GLSB){1'b1}}, {GLSB{1'b0}}};

    always_comb begin
        hit = req && held && (((addr ^ ref_addr) & GMASK) == '0);
    end
endmodule

// File: rtl/resv_fsm.sv
module resv_fsm
    import resv_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lr_req,
    input  logic [AW-1:0] lr_addr,
    input  logic          sc_req,
    input  logic          kill,
    input  logic          trap_evt,
    output logic          held,
    output logic [AW-1:0] resv_addr
);
    resv_state_e   state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NO_RESV;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            NO_RESV: begin
                if (lr_req) begin            // RESERVE
                    state_d = RESV_HELD;
                    addr_d  = lr_addr;
                end
            end
            RESV_HELD: begin
                if (lr_req) begin            // RELOAD (wins over a same-cycle snoop)
                    state_d = RESV_HELD;
                    addr_d  = lr_addr;
                end else if (sc_req) begin   // CONSUME, pass or fail
                    state_d = NO_RESV;
                end else if (kill) begin     // KILL by snoop or local store
                    state_d = NO_RESV;
                end else if (trap_evt) begin // traps keep the reservation
                    state_d = RESV_HELD;
                end
            end
            default: state_d = NO_RESV;
        endcase
    end

    assign held      = (state_q == RESV_HELD);
    assign resv_addr = addr_q;
endmodule

// File: rtl/resv_outcome.sv
module resv_outcome
    import resv_pkg::*;
#(
    parameter int AW   = 32,
    parameter int WLSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sc_req,
    input  logic [AW-1:0]   sc_addr,
    input  logic [AW-1:0]   resv_addr,
    input  logic            held,
    input  logic            kill,
    input  logic            so_flag,
    output logic            mem_we,
    output logic            cr_vld,
    output logic [CR_W-1:0] cr_fld
);
    localparam logic [AW-1:0] WMASK = {{(AW-WLSB){1'b1}}, {WLSB{1'b0}}};

    logic word_eq;
    logic pass;

    always_comb begin
        word_eq = (((sc_addr ^ resv_addr) & WMASK) == '0);
        pass    = sc_req && held && word_eq && !kill;
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we <= 1'b0;
            cr_vld <= 1'b0;
            cr_fld <= '0;
        end else begin
            mem_we <= pass;
            cr_vld <= sc_req;
            if (sc_req) begin
                cr_fld        <= '0;
                cr_fld[CR_EQ] <= pass;
                cr_fld[CR_SO] <= so_flag;
            end
        end
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int AW   = 32,
    parameter int GLSB = 5,
    parameter int WLSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lr_req,
    input  logic [AW-1:0]   lr_addr,
    input  logic            st_req,
    input  logic [AW-1:0]   st_addr,
    input  logic            snp_req,
    input  logic [AW-1:0]   snp_addr,
    input  logic            sc_req,
    input  logic [AW-1:0]   sc_addr,
    input  logic            so_flag,
    input  logic            trap_evt,
    output logic            mem_we,
    output logic            cr_vld,
    output logic [CR_W-1:0] cr_fld,
    output logic            resv_valid
);
    logic                held;
    logic [AW-1:0]       resv_addr;
    logic [N_WATCH-1:0]  w_req;
    logic [AW-1:0]       w_addr [N_WATCH];
    logic [N_WATCH-1:0]  w_hit;
    logic                kill;

    assign w_req[0]  = snp_req;
    assign w_addr[0] = snp_addr;
    assign w_req[1]  = st_req;
    assign w_addr[1] = st_addr;

    for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
        resv_granule_cmp #(.AW(AW), .GLSB(GLSB)) u_cmp (
            .req      (w_req[g]),
            .addr     (w_addr[g]),
            .ref_addr (resv_addr),
            .held     (held),
            .hit      (w_hit[g])
        );
    end

    assign kill = |w_hit;

    resv_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lr_req    (lr_req),
        .lr_addr   (lr_addr),
        .sc_req    (sc_req),
        .kill      (kill),
        .trap_evt  (trap_evt),
        .held      (held),
        .resv_addr (resv_addr)
    );

    resv_outcome #(.AW(AW), .WLSB(WLSB)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_req    (sc_req),
        .sc_addr   (sc_addr),
        .resv_addr (resv_addr),
        .held      (held),
        .kill      (kill),
        .so_flag   (so_flag),
        .mem_we    (mem_we),
        .cr_vld    (cr_vld),
        .cr_fld    (cr_fld)
    );

    assign resv_valid = held;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int AW   = 32,
    parameter int GLSB = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lr_req,
    input logic          st_req,
    input logic          snp_req,
    input logic [AW-1:0] snp_addr,
    input logic          sc_req,
    input logic          so_flag,
    input logic          trap_evt,
    input logic          mem_we,
    input logic          cr_vld,
    input logic [3:0]    cr_fld,
    input logic          resv_valid,
    input logic [AW-1:0] resv_addr
);
    logic snp_same;
    assign snp_same = snp_req && (snp_addr[AW-1:GLSB] == resv_addr[AW-1:GLSB]);

    assert_core_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lr_req, st_req, sc_req}));

    assert_we_needs_resv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(sc_req) && $past(resv_valid)));

    assert_sc_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> !resv_valid);

    assert_field_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cr_vld |-> (cr_fld[3:2] == 2'b00 && cr_fld[0] == $past(so_flag)));

    assert_snoop_kills_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_valid && snp_same && !lr_req) |=> !resv_valid);

    assert_snoop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_valid && snp_same && sc_req) |=> !mem_we);

    assert_trap_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_evt && !lr_req && !st_req && !sc_req && !snp_req) |=> $stable(resv_valid));

    assert_cr_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cr_vld == $past(sc_req));
endmodule

bind resv_monitor resv_monitor_chk #(.AW(AW), .GLSB(GLSB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lr_req     (lr_req),
    .st_req     (st_req),
    .snp_req    (snp_req),
    .snp_addr   (snp_addr),
    .sc_req     (sc_req),
    .so_flag    (so_flag),
    .trap_evt   (trap_evt),
    .mem_we     (mem_we),
    .cr_vld     (cr_vld),
    .cr_fld     (cr_fld),
    .resv_valid (resv_valid),
    .resv_addr  (resv_addr)
);

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;
    localparam int AW = 32;
    localparam int VW = 81;
    localparam int NV = 22;
    localparam logic [2:0] OP_NONE = 3'd0, OP_LR = 3'd1, OP_ST = 3'd2, OP_SC = 3'd3;
    localparam logic [31:0] A  = 32'h0000_1040;

    // {op, addr, snp, snp_addr, so, trap, req, exp_valid, exp_we, exp_cvld, exp_fld}
    localparam logic [VW-1:0] VEC [NV] = '{
        {OP_LR,   A,             1'b0, 32'h0,        1'b0, 1'b0, 4'd2,  1'b1, 1'b0, 1'b0, 4'h0}, // R2
        {OP_NONE, 32'h0,         1'b0, 32'h0,        1'b0, 1'b0, 4'd11, 1'b1, 1'b0, 1'b0, 4'h0}, // R11
        {OP_NONE, 32'h0,         1'b0, 32'h0,        1'b0, 1'b1, 4'd10, 1'b1, 1'b0, 1'b0, 4'h0}, // R10
        {OP_SC,   A,             1'b0, 32'h0,        1'b0, 1'b0, 4'd5,  1'b0, 1'b1, 1'b1, 4'h2}, // R5 R7
        {OP_SC,   A,             1'b0, 32'h0,        1'b1, 1'b0, 4'd6,  1'b0, 1'b0, 1'b1, 4'h1}, // R6
        {OP_LR,   A,             1'b0, 32'h0,        1'b0, 1'b0, 4'd13, 1'b1, 1'b0, 1'b0, 4'h1}, // R13
        {OP_NONE, 32'h0,         1'b1, 32'h0000_1060,1'b0, 1'b0, 4'd3,  1'b1, 1'b0, 1'b0, 4'h1}, // R3
        {OP_NONE, 32'h0,         1'b1, 32'h0000_105C,1'b0, 1'b0, 4'd3,  1'b0, 1'b0, 1'b0, 4'h1}, // R3
        {OP_LR,   A,             1'b0, 32'h0,        1'b0, 1'b0, 4'd2,  1'b1, 1'b0, 1'b0, 4'h1},
        {OP_ST,   32'h0000_1050, 1'b0, 32'h0,        1'b0, 1'b0, 4'd4,  1'b0, 1'b0, 1'b0, 4'h1}, // R4
        {OP_LR,   A,             1'b0, 32'h0,        1'b0, 1'b0, 4'd2,  1'b1, 1'b0, 1'b0, 4'h1},
        {OP_ST,   32'h0000_2000, 1'b0, 32'h0,        1'b0, 1'b0, 4'd4,  1'b1, 1'b0, 1'b0, 4'h1}, // R4
        {OP_SC,   32'h0000_1044, 1'b0, 32'h0,        1'b0, 1'b0, 4'd8,  1'b0, 1'b0, 1'b1, 4'h0}, // R8
        {OP_LR,   A,             1'b0, 32'h0,        1'b0, 1'b0, 4'd2,  1'b1, 1'b0, 1'b0, 4'h0},
        {OP_SC,   A,             1'b1, 32'h0000_1058,1'b1, 1'b0, 4'd9,  1'b0, 1'b0, 1'b1, 4'h1}, // R9
        {OP_LR,   32'h0000_1060, 1'b1, 32'h0000_1060,1'b0, 1'b0, 4'd12, 1'b1, 1'b0, 1'b0, 4'h1}, // R12
        {OP_SC,   32'h0000_1060, 1'b0, 32'h0,        1'b0, 1'b0, 4'd12, 1'b0, 1'b1, 1'b1, 4'h2}, // R12
        {OP_LR,   A,             1'b0, 32'h0,        1'b0, 1'b1, 4'd10, 1'b1, 1'b0, 1'b0, 4'h2}, // R10
        {OP_SC,   A,             1'b0, 32'h0,        1'b1, 1'b1, 4'd10, 1'b0, 1'b1, 1'b1, 4'h3}, // R10
        {OP_LR,   32'h0000_2000, 1'b0, 32'h0,        1'b0, 1'b0, 4'd11, 1'b1, 1'b0, 1'b0, 4'h3}, // R11
        {OP_LR,   A,             1'b0, 32'h0,        1'b0, 1'b0, 4'd11, 1'b1, 1'b0, 1'b0, 4'h3}, // R11
        {OP_SC,   32'h0000_2000, 1'b0, 32'h0,        1'b0, 1'b0, 4'd11, 1'b0, 1'b0, 1'b1, 4'h0}  // R11
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lr_req, st_req, snp_req, sc_req, so_flag, trap_evt;
    logic [AW-1:0] lr_addr, st_addr, snp_addr, sc_addr;
    logic          mem_we, cr_vld, resv_valid;
    logic [3:0]    cr_fld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    resv_monitor u_dut (
        .clk(clk), .rst_n(rst_n),
        .lr_req(lr_req), .lr_addr(lr_addr),
        .st_req(st_req), .st_addr(st_addr),
        .snp_req(snp_req), .snp_addr(snp_addr),
        .sc_req(sc_req), .sc_addr(sc_addr),
        .so_flag(so_flag), .trap_evt(trap_evt),
        .mem_we(mem_we), .cr_vld(cr_vld), .cr_fld(cr_fld),
        .resv_valid(resv_valid)
    );

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s {valid,we,cvld,fld} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [AW-1:0] a, input logic snp,
                         input logic [AW-1:0] sa, input logic so, input logic trap);
        lr_req   = (op == OP_LR);
        st_req   = (op == OP_ST);
        sc_req   = (op == OP_SC);
        lr_addr  = a;
        st_addr  = a;
        sc_addr  = a;
        snp_req  = snp;
        snp_addr = sa;
        so_flag  = so;
        trap_evt = trap;
    endtask

    // drive at a falling edge, let one rising edge pass, sample at the next falling edge
    task automatic step(input logic [2:0] op, input logic [AW-1:0] a, input logic snp,
                        input logic [AW-1:0] sa, input logic so, input logic trap);
        drive(op, a, snp, sa, so, trap);
        @(negedge clk);
    endtask

    function automatic logic [6:0] obs();
        return {resv_valid, mem_we, cr_vld, cr_fld};
    endfunction

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(OP_NONE, '0, 1'b0, '0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 in reset", obs(), 7'b0000000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", obs(), 7'b0000000);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            step(v[80:78], v[77:46], v[45], v[44:13], v[12], v[11]);
            check($sformatf("R%0d vec%0d", v[10:7], i), obs(), v[6:0]);
        end

        // R5 R13: the write-enable is a single pulse and the field holds afterwards
        step(OP_LR, A, 1'b0, '0, 1'b0, 1'b0);
        step(OP_SC, A, 1'b0, '0, 1'b0, 1'b0);
        check("R5 pass pulse", obs(), 7'b0110010);
        step(OP_NONE, '0, 1'b0, '0, 1'b0, 1'b0);
        check("R13 hold after pulse", obs(), 7'b0000010);

        // R11: a long abandoned reservation still allows a later pass
        step(OP_LR, A, 1'b0, '0, 1'b0, 1'b0);
        repeat (2000) @(negedge clk);
        check("R11 still held", obs(), 7'b1000010);
        step(OP_SC, A, 1'b0, '0, 1'b1, 1'b0);
        check("R11 late pass", obs(), 7'b0110011);

        // R3: a snoop to another granule in the conditional-store cycle does not block it
        step(OP_LR, A, 1'b0, '0, 1'b0, 1'b0);
        step(OP_SC, A, 1'b1, 32'h0000_3000, 1'b0, 1'b0);
        check("R3 other granule snoop", obs(), 7'b0110010);

        // R1: reset drops a held reservation
        step(OP_LR, A, 1'b0, '0, 1'b0, 1'b0);
        drive(OP_NONE, '0, 1'b0, '0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid reservation", obs(), 7'b0000000);
        rst_n = 1'b1;
        step(OP_SC, A, 1'b0, '0, 1'b0, 1'b0);
        check("R1 no resv after reset", obs(), 7'b0010000);

        drive(OP_NONE, '0, 1'b0, '0, 1'b0, 1'b0);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule